// File: doc/BRIEF.md
# Memory-Management Access Trap Controller

This block sits beside the protection checker of a memory-management unit. On every access check it decides whether the access meets the trap condition of the segment's access control field. From that it produces three single-cycle strobes: one sets the attention (A) bit of the selected segment descriptor, one sets its written (W) bit, and one sets the trap flag in status register 0. Address relocation, length checks and abort detection happen elsewhere; their result arrives here as an abort input.

The block also owns the trap request. The live trap-enable bit (bit 9 of status register 0) is captured when an instruction starts, and that captured value governs the whole instruction. An instruction that clears the enable and also meets a trap condition therefore still traps. A trap is requested at most once per instruction, as a one-cycle pulse after the instruction ends.

Top module: `mmu_trap_ctl`

## Requirements
- R1: After reset, `trap_req`, `sr0_flag_set`, `desc_set_a` and `desc_set_w` are all 0.
- R2: The strobes follow the cycle in which `chk_valid` is high by one clock. The access kind is coded as 00 read, 01 write, 10 read-modify-write, and 11 counts as read.
- R3: With control code 001, a read sets A and the status flag. A write or read-modify-write does not.
- R4: With control code 100, a read, a write and a read-modify-write each set A and the status flag.
- R5: With control code 101, a write or read-modify-write sets A and the status flag. A read does not.
- R6: Control codes 010 and 110 never set A or the status flag, whatever the access kind.
- R7: A non-aborted write or read-modify-write sets W under any permitted control code. A read never sets W.
- R8: When `abort_in` is high, the check sets none of A, W and the status flag, and it adds nothing toward a trap.
- R9: Control codes 000, 011 and 111 count as denied. They set none of A, W and the status flag even when `abort_in` is low.
- R10: `trap_req` is high for exactly one cycle, the cycle after `instr_end`, and only when the instruction had at least one trapping check and its captured enable is 1. Several trapping checks in one instruction give a single pulse.
- R11: The enable is captured from `sr0_trap_en` in the cycle `instr_start` is high. Changing `sr0_trap_en` later within the instruction does not change whether that instruction traps.
- R12: An instruction with no trapping check raises no `trap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_start | input | 1 | First cycle of an instruction |
| instr_end | input | 1 | Last cycle of an instruction |
| sr0_trap_en | input | 1 | Live trap-enable bit from status register 0 |
| chk_valid | input | 1 | An access check is presented this cycle |
| acf | input | 3 | Access control field of the selected descriptor |
| acc_kind | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 read |
| abort_in | input | 1 | The protection check aborted this access |
| trap_req | output | 1 | One-cycle trap request to the sequencer |
| sr0_flag_set | output | 1 | Set strobe for the status register 0 trap flag |
| desc_set_a | output | 1 | Set strobe for descriptor bit A |
| desc_set_w | output | 1 | Set strobe for descriptor bit W |

## Verification
If the control-code decode goes wrong, the A or status strobe takes the wrong value one cycle after the offending check. The access-kind patterns applied to each code expose such a fault at once. If the captured enable or the per-instruction pending flag is corrupted, the symptom shows up only one cycle after `instr_end`: the trap pulse is missing, appears when it should not, or repeats. For that reason the bench toggles the live enable inside an instruction and places several trapping checks in one instruction.

// File: rtl/mmu_trap_pkg.sv
package mmu_trap_pkg;
    localparam int ACF_W  = 3;
    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_RMW   = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_t;

    typedef struct packed {
        logic flag;
        logic set_a;
        logic set_w;
    } strobe_t;

    typedef struct packed {
        logic en;
        logic pend;
        logic trap;
    } window_t;
endpackage

// File: rtl/mmu_acf_decode.sv
module mmu_acf_decode
    import mmu_trap_pkg::*;
(
    input  logic [ACF_W-1:0]  acf,
    input  logic [KIND_W-1:0] kind,
    output logic              trap_cond,
    output logic              denied
);
    acc_kind_t k;
    logic      writes;

    always_comb begin
        k      = acc_kind_t'(kind);
        writes = (k == ACC_WRITE) || (k == ACC_RMW);
        trap_cond = 1'b0;
        denied    = 1'b0;
        case (acf)
            3'b001:  trap_cond = !writes;
            3'b100:  trap_cond = 1'b1;
            3'b101:  trap_cond = writes;
            3'b000,
            3'b011,
            3'b111:  denied = 1'b1;
            default: trap_cond = 1'b0;
        endcase
    end
endmodule

// File: rtl/mmu_instr_window.sv
module mmu_instr_window
    import mmu_trap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_start,
    input  logic instr_end,
    input  logic en_live,
    input  logic hit,
    output logic trap_pulse
);
    window_t w_d, w_q;
    logic    en_eff;
    logic    pend_eff;

    always_comb begin
        en_eff   = instr_start ? en_live : w_q.en;
        pend_eff = (instr_start ? 1'b0 : w_q.pend) | hit;
        w_d.en   = en_eff;
        w_d.pend = instr_end ? 1'b0 : pend_eff;
        w_d.trap = instr_end & pend_eff & en_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign trap_pulse = w_q.trap;
endmodule

// File: rtl/mmu_trap_ctl.sv
module mmu_trap_ctl
    import mmu_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_start,
    input  logic              instr_end,
    input  logic              sr0_trap_en,
    input  logic              chk_valid,
    input  logic [ACF_W-1:0]  acf,
    input  logic [KIND_W-1:0] acc_kind,
    input  logic              abort_in,
    output logic              trap_req,
    output logic              sr0_flag_set,
    output logic              desc_set_a,
    output logic              desc_set_w
);
    logic    cond, denied, ok, hit, writes;
    strobe_t s_d, s_q;

    mmu_acf_decode u_dec (
        .acf       (acf),
        .kind      (acc_kind),
        .trap_cond (cond),
        .denied    (denied)
    );

    always_comb begin
        writes    = (acc_kind == ACC_WRITE) || (acc_kind == ACC_RMW);
        ok        = chk_valid & ~abort_in & ~denied;
        hit       = ok & cond;
        s_d.flag  = hit;
        s_d.set_a = hit;
        s_d.set_w = ok & writes;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    mmu_instr_window u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_start (instr_start),
        .instr_end   (instr_end),
        .en_live     (sr0_trap_en),
        .hit         (hit),
        .trap_pulse  (trap_req)
    );

    assign sr0_flag_set = s_q.flag;
    assign desc_set_a   = s_q.set_a;
    assign desc_set_w   = s_q.set_w;
endmodule

// File: rtl/mmu_trap_ctl_chk.sv
module mmu_trap_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       instr_end,
    input logic       chk_valid,
    input logic [2:0] acf,
    input logic [1:0] acc_kind,
    input logic       abort_in,
    input logic       trap_req,
    input logic       sr0_flag_set,
    input logic       desc_set_a,
    input logic       desc_set_w
);
    logic live_q;
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(chk_valid && abort_in) |-> !desc_set_a && !desc_set_w && !sr0_flag_set);

    assert_trap_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> live_q && $past(instr_end));

    assert_trap_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    assert_no_write_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        desc_set_w |-> live_q && $past(chk_valid) && ($past(acc_kind) == 2'b01 || $past(acc_kind) == 2'b10));

    assert_quiet_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(chk_valid && (acf == 3'b010 || acf == 3'b110)) |-> !desc_set_a && !sr0_flag_set);

    assert_denied_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(chk_valid && (acf == 3'b000 || acf == 3'b011 || acf == 3'b111))
        |-> !desc_set_a && !desc_set_w && !sr0_flag_set);

    assert_flag_needs_check_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_set_a || sr0_flag_set) |-> live_q && $past(chk_valid));
endmodule

bind mmu_trap_ctl mmu_trap_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_end    (instr_end),
    .chk_valid    (chk_valid),
    .acf          (acf),
    .acc_kind     (acc_kind),
    .abort_in     (abort_in),
    .trap_req     (trap_req),
    .sr0_flag_set (sr0_flag_set),
    .desc_set_a   (desc_set_a),
    .desc_set_w   (desc_set_w)
);

// File: tb/mmu_trap_ctl_test.sv
module mmu_trap_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_start = 1'b0, instr_end = 1'b0, sr0_trap_en = 1'b0;
    logic       chk_valid = 1'b0, abort_in = 1'b0;
    logic [2:0] acf = 3'b0;
    logic [1:0] acc_kind = 2'b0;
    logic       trap_req, sr0_flag_set, desc_set_a, desc_set_w;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    tb_en = 1'b0;
    bit    tb_pend = 1'b0;
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_trap_ctl uut (
        .clk(clk), .rst_n(rst_n), .instr_start(instr_start), .instr_end(instr_end),
        .sr0_trap_en(sr0_trap_en), .chk_valid(chk_valid), .acf(acf), .acc_kind(acc_kind),
        .abort_in(abort_in), .trap_req(trap_req), .sr0_flag_set(sr0_flag_set),
        .desc_set_a(desc_set_a), .desc_set_w(desc_set_w)
    );

    function automatic bit model_cond(input logic [2:0] c, input logic [1:0] k);
        bit wr = (k == 2'b01) || (k == 2'b10);
        case (c)
            3'b001:  return !wr;
            3'b100:  return 1'b1;
            3'b101:  return wr;
            default: return 1'b0;
        endcase
    endfunction

    task automatic cyc(input bit st, input bit en_, input bit en_live, input bit chk,
                       input logic [2:0] c, input logic [1:0] k, input bit ab, input string tag);
        bit ok, hit, wr, eff_en, eff_pend, tr;
        @(negedge clk);
        instr_start = st; instr_end = en_; sr0_trap_en = en_live;
        chk_valid = chk; acf = c; acc_kind = k; abort_in = ab;
        wr  = (k == 2'b01) || (k == 2'b10);
        ok  = chk && !ab && !(c == 3'b000 || c == 3'b011 || c == 3'b111);
        hit = ok && model_cond(c, k);
        eff_en   = st ? en_live : tb_en;
        eff_pend = (st ? 1'b0 : tb_pend) | hit;
        tr = en_ && eff_pend && eff_en;
        tb_en   = eff_en;
        tb_pend = en_ ? 1'b0 : eff_pend;
        q.push_back('{exp: {tr, hit, hit, ok && wr}, tag: tag});
    endtask

    task automatic idle(input bit en_live);
        cyc(0, 0, en_live, 0, 3'b000, 2'b00, 0, "idle");
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it  = q.pop_front();
                act = {trap_req, sr0_flag_set, desc_set_a, desc_set_w};
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: {trap,flag,a,w} actual %b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        n_checks++;
        if ({trap_req, sr0_flag_set, desc_set_a, desc_set_w} !== 4'b0000) begin
            n_fail++;
            $display("FAIL R1: reset outputs actual %b expected 0000",
                     {trap_req, sr0_flag_set, desc_set_a, desc_set_w});
        end
        @(negedge clk); rst_n = 1'b1;
        idle(0);

        // R3 code 001
        cyc(1, 0, 1, 1, 3'b001, 2'b00, 0, "R3 read on 001");
        cyc(0, 0, 1, 1, 3'b001, 2'b01, 0, "R3 write on 001");
        cyc(0, 0, 1, 1, 3'b001, 2'b11, 0, "R2 kind 11 as read on 001");
        cyc(0, 1, 1, 0, 3'b000, 2'b00, 0, "R10 trap after end");
        idle(1);
        // R4 code 100
        for (int kk = 0; kk < 3; kk++)
            cyc(kk == 0, 0, 0, 1, 3'b100, kk[1:0], 0, "R4 code 100");
        cyc(0, 1, 0, 0, 3'b000, 2'b00, 0, "R12 enable off no trap");
        // R5 code 101
        for (int kk = 0; kk < 3; kk++)
            cyc(kk == 0, 0, 0, 1, 3'b101, kk[1:0], 0, "R5 code 101");
        // R6 / R7 quiet codes
        for (int kk = 0; kk < 3; kk++) begin
            cyc(0, 0, 0, 1, 3'b010, kk[1:0], 0, "R6 R7 code 010");
            cyc(0, 0, 0, 1, 3'b110, kk[1:0], 0, "R6 R7 code 110");
        end
        // R9 denied codes
        for (int kk = 0; kk < 3; kk++) begin
            cyc(0, 0, 0, 1, 3'b000, kk[1:0], 0, "R9 code 000");
            cyc(0, 0, 0, 1, 3'b011, kk[1:0], 0, "R9 code 011");
            cyc(0, 0, 0, 1, 3'b111, kk[1:0], 0, "R9 code 111");
        end
        cyc(0, 1, 0, 0, 3'b000, 2'b00, 0, "R12 end");
        // R8 abort
        cyc(1, 0, 1, 1, 3'b100, 2'b01, 1, "R8 abort write 100");
        cyc(0, 0, 1, 1, 3'b001, 2'b00, 1, "R8 abort read 001");
        cyc(0, 1, 1, 0, 3'b000, 2'b00, 0, "R8 abort gives no trap");
        idle(1);
        // R11 enable cleared mid-instruction still traps
        cyc(1, 0, 1, 0, 3'b000, 2'b00, 0, "R11 start en=1");
        cyc(0, 0, 0, 1, 3'b100, 2'b01, 0, "R11 hit after clear");
        cyc(0, 1, 0, 0, 3'b000, 2'b00, 0, "R11 trap still raised");
        idle(0);
        // R11 enable set mid-instruction does not trap
        cyc(1, 0, 0, 1, 3'b100, 2'b00, 0, "R11 start en=0 hit");
        cyc(0, 0, 1, 0, 3'b000, 2'b00, 0, "R11 set enable");
        cyc(0, 1, 1, 0, 3'b000, 2'b00, 0, "R11 no trap");
        idle(1);
        // R10 multiple hits one pulse, then next instruction clean (R12)
        cyc(1, 0, 1, 1, 3'b100, 2'b00, 0, "R10 hit 1");
        cyc(0, 0, 1, 1, 3'b101, 2'b10, 0, "R10 hit 2");
        cyc(0, 0, 1, 1, 3'b001, 2'b00, 0, "R10 hit 3");
        cyc(0, 1, 1, 0, 3'b000, 2'b00, 0, "R10 single pulse");
        idle(1);
        idle(1);
        cyc(1, 0, 1, 1, 3'b010, 2'b01, 0, "R12 new instr no hit");
        cyc(0, 1, 1, 0, 3'b000, 2'b00, 0, "R12 no trap");
        // single-cycle instruction with hit
        cyc(1, 1, 1, 1, 3'b100, 2'b01, 0, "R10 one-cycle instr");
        idle(1);
        idle(1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule